// File: doc/BRIEF.md
# Stop-Mode Wake-Up Clock Controller

This block sequences the clock system of a microcontroller as it leaves full stop mode. In stop, the oscillator and the clock monitor are both off. Only two events end stop: an external reset or a wake-up interrupt. The block then takes one of three paths, and each path decides which clock source the system runs on afterwards.

On the reset path, the configuration is restored at once. The block runs a bounded series of clock check windows and then starts the reset generator. On the normal interrupt path, the same bounded series of windows runs. A pass returns the system to the oscillator. If every window fails, the system either falls back to the self-clock or asks for a clock monitor reset. On the fast interrupt path, the system resumes at once on the self-clock with the oscillator kept off. When software later clears the fast-wake bit, the oscillator starts and a quality check runs. A pass moves the system to the oscillator and raises a sticky status flag.

Each check window is `WIN_CYC` cycles long, with `WIN_CYC` at least 2. At most `MAX_WIN` windows run per attempt. Every exit from stop also emits a pulse that clears the PLL select bit, so the system runs on the oscillator clock until software selects the PLL again.

Top module: `stop_wake_ctrl`

## Requirements
- R1: From run mode, a high `stop_req_i` enters stop. In stop, `osc_en_o` and `mon_en_o` are 0. Only `ext_rst_i` or `wake_irq_i` leave stop; `qc_pass_i`, `fast_wake_i` and `scm_en_i` alone have no effect there.
- R2: While in stop with `ext_rst_i` high, `cfg_default_o` is 1 combinationally, before any clock edge. An external reset takes priority over a simultaneous interrupt.
- R3: On the reset path, once the check ends (first pass or all `MAX_WIN` windows failed), `rst_gen_start_o` pulses for one cycle. The block returns to run with `clk_sel_o`=0 (oscillator), and `cm_rst_o` stays 0.
- R4: During a check, each window lasts `WIN_CYC` cycles. `qc_start_o` is 1 only in the first cycle of each window. `qc_pass_i` is sampled in the last cycle of each window, and the check ends at the first pass.
- R5: A wake-up interrupt with `fast_wake_i`=0 or `scm_en_i`=0 runs the normal check. On a pass, the block returns to run with `clk_sel_o`=0, and `scm_flag_o` stays 0.
- R6: When all windows fail on an interrupt path, `scm_en_i`=1 leaves the block on the self-clock (`clk_sel_o`=1, where 1 selects self-clock and 0 the oscillator). With `scm_en_i`=0, `cm_rst_o` pulses for one cycle and the block returns to run.
- R7: A wake-up interrupt with `fast_wake_i`=1 and `scm_en_i`=1 gives `clk_sel_o`=1 in the next cycle, with `osc_en_o`=0 and `mon_en_o`=0. This holds for as long as `fast_wake_i` stays 1.
- R8: After a fast wake-up, clearing `fast_wake_i` turns on `osc_en_o` and starts a check while `clk_sel_o` stays 1. On a pass, `clk_sel_o` becomes 0 and `scm_flag_o` becomes 1 in the same cycle. On total failure, the block stays on the self-clock with the flag unchanged.
- R9: `pll_sel_clr_o` pulses for exactly one cycle, in the cycle after every exit from stop.
- R10: `scm_flag_o` is sticky. A one-cycle high on `scm_flag_clr_i` clears it in the next cycle, and a set in the same cycle wins.
- R11: After reset, the block is in run mode with `clk_sel_o`=0, `osc_en_o`=1 and `mon_en_o`=1. All pulse outputs, `qc_start_o` and `scm_flag_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_req_i | input | 1 | Request to enter full stop from run |
| ext_rst_i | input | 1 | External reset pin level |
| wake_irq_i | input | 1 | Wake-up interrupt |
| fast_wake_i | input | 1 | Fast-wake enable bit |
| scm_en_i | input | 1 | Self-clock mode enable bit |
| qc_pass_i | input | 1 | Quality checker result, valid in the last cycle of a window |
| scm_flag_clr_i | input | 1 | Write-one-to-clear strobe for the status flag |
| osc_en_o | output | 1 | Oscillator enable |
| mon_en_o | output | 1 | Clock monitor enable |
| qc_start_o | output | 1 | Start of a quality check window |
| clk_sel_o | output | 1 | System clock source, 0 oscillator, 1 self-clock |
| scm_flag_o | output | 1 | Sticky self-clock-mode status flag |
| cm_rst_o | output | 1 | Clock monitor reset request pulse |
| rst_gen_start_o | output | 1 | Reset generator start pulse |
| pll_sel_clr_o | output | 1 | Clear pulse for the PLL select bit |
| cfg_default_o | output | 1 | Asynchronous configuration restore |

## Verification
The assertions assume that `scm_en_i` is stable across the edge where a check ends. They also assume that `fast_wake_i` changes only by software action and not within the cycle of a wake-up. The stimulus holds every mode bit constant from the wake-up until the outcome has been sampled, and changes inputs only at falling edges. For each path, the sweep places the first passing window at every index and also covers the case where every window fails.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_STOP, ST_CHECK, ST_SCM_FAST, ST_SCM
  } swk_state_e;

  typedef enum logic [1:0] {
    ORG_RST, ORG_IRQ, ORG_FAST
  } swk_org_e;
endpackage

// File: rtl/swk_win_timer.sv
module swk_win_timer #(
  parameter int unsigned WIN_CYC = 4096,
  parameter int unsigned MAX_WIN = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic win_start_o,
  output logic win_end_o,
  output logic last_win_o
);
  localparam int unsigned CW = $clog2(WIN_CYC + 1);
  localparam int unsigned NW = $clog2(MAX_WIN + 1);

  logic [CW-1:0] cyc_q;
  logic [NW-1:0] win_q;

  assign win_start_o = run_i && (cyc_q == '0);
  assign win_end_o   = run_i && (cyc_q == CW'(WIN_CYC - 1));
  assign last_win_o  = (win_q == NW'(MAX_WIN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      win_q <= '0;
    end else if (!run_i) begin
      cyc_q <= '0;
      win_q <= '0;
    end else if (win_end_o) begin
      cyc_q <= '0;
      if (!last_win_o) win_q <= win_q + NW'(1);
    end else begin
      cyc_q <= cyc_q + CW'(1);
    end
  end
endmodule

// File: rtl/swk_fsm.sv
module swk_fsm
  import swk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_req_i,
  input  logic       ext_rst_i,
  input  logic       wake_irq_i,
  input  logic       fast_wake_i,
  input  logic       scm_en_i,
  input  logic       qc_pass_i,
  input  logic       scm_flag_clr_i,
  input  logic       win_end_i,
  input  logic       last_win_i,
  output swk_state_e state_o,
  output swk_org_e   org_o,
  output logic       scm_flag_o,
  output logic       cm_rst_o,
  output logic       rst_gen_o,
  output logic       pll_clr_o
);
  swk_state_e state_q, state_d;
  swk_org_e   org_q, org_d;
  logic       flag_set, cm_d, rg_d, pll_d;

  always_comb begin
    state_d  = state_q;
    org_d    = org_q;
    flag_set = 1'b0;
    cm_d     = 1'b0;
    rg_d     = 1'b0;
    pll_d    = 1'b0;
    unique case (state_q)
      ST_RUN: if (stop_req_i) state_d = ST_STOP;
      ST_STOP: begin
        if (ext_rst_i) begin
          state_d = ST_CHECK;
          org_d   = ORG_RST;
          pll_d   = 1'b1;
        end else if (wake_irq_i) begin
          pll_d = 1'b1;
          if (fast_wake_i && scm_en_i) begin
            state_d = ST_SCM_FAST;
          end else begin
            state_d = ST_CHECK;
            org_d   = ORG_IRQ;
          end
        end
      end
      ST_SCM_FAST: if (!fast_wake_i) begin
        state_d = ST_CHECK;
        org_d   = ORG_FAST;
      end
      ST_CHECK: if (win_end_i && (qc_pass_i || last_win_i)) begin
        state_d = ST_RUN;
        if (org_q == ORG_RST) begin
          rg_d = 1'b1;
        end else if (qc_pass_i) begin
          flag_set = (org_q == ORG_FAST);
        end else if (scm_en_i) begin
          state_d = ST_SCM;
        end else begin
          cm_d = 1'b1;
        end
      end
      ST_SCM: state_d = ST_SCM;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      org_q      <= ORG_IRQ;
      scm_flag_o <= 1'b0;
      cm_rst_o   <= 1'b0;
      rst_gen_o  <= 1'b0;
      pll_clr_o  <= 1'b0;
    end else begin
      state_q   <= state_d;
      org_q     <= org_d;
      cm_rst_o  <= cm_d;
      rst_gen_o <= rg_d;
      pll_clr_o <= pll_d;
      if (flag_set)            scm_flag_o <= 1'b1;
      else if (scm_flag_clr_i) scm_flag_o <= 1'b0;
    end
  end

  assign state_o = state_q;
  assign org_o   = org_q;
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swk_pkg::*;
#(
  parameter int unsigned WIN_CYC = 4096,
  parameter int unsigned MAX_WIN = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  input  logic ext_rst_i,
  input  logic wake_irq_i,
  input  logic fast_wake_i,
  input  logic scm_en_i,
  input  logic qc_pass_i,
  input  logic scm_flag_clr_i,
  output logic osc_en_o,
  output logic mon_en_o,
  output logic qc_start_o,
  output logic clk_sel_o,
  output logic scm_flag_o,
  output logic cm_rst_o,
  output logic rst_gen_start_o,
  output logic pll_sel_clr_o,
  output logic cfg_default_o
);
  swk_state_e state;
  swk_org_e   org;
  logic       win_start, win_end, last_win, checking;

  assign checking = (state == ST_CHECK);

  swk_win_timer #(.WIN_CYC(WIN_CYC), .MAX_WIN(MAX_WIN)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (checking),
    .win_start_o (win_start),
    .win_end_o   (win_end),
    .last_win_o  (last_win)
  );

  swk_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .stop_req_i     (stop_req_i),
    .ext_rst_i      (ext_rst_i),
    .wake_irq_i     (wake_irq_i),
    .fast_wake_i    (fast_wake_i),
    .scm_en_i       (scm_en_i),
    .qc_pass_i      (qc_pass_i),
    .scm_flag_clr_i (scm_flag_clr_i),
    .win_end_i      (win_end),
    .last_win_i     (last_win),
    .state_o        (state),
    .org_o          (org),
    .scm_flag_o     (scm_flag_o),
    .cm_rst_o       (cm_rst_o),
    .rst_gen_o      (rst_gen_start_o),
    .pll_clr_o      (pll_sel_clr_o)
  );

  // oscillator and monitor are off in stop and in fast self-clock
  assign osc_en_o      = !(state == ST_STOP || state == ST_SCM_FAST);
  assign mon_en_o      = osc_en_o;
  assign qc_start_o    = win_start;
  assign clk_sel_o     = (state == ST_SCM) || (state == ST_SCM_FAST) ||
                         (checking && org == ORG_FAST);
  assign cfg_default_o = (state == ST_STOP) && ext_rst_i;
endmodule

// File: rtl/stop_wake_ctrl_chk.sv
module stop_wake_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fast_wake_i,
  input logic scm_en_i,
  input logic osc_en_o,
  input logic mon_en_o,
  input logic qc_start_o,
  input logic clk_sel_o,
  input logic scm_flag_o,
  input logic cm_rst_o,
  input logic rst_gen_start_o,
  input logic pll_sel_clr_o
);
  // R9
  pll_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_sel_clr_o |=> !pll_sel_clr_o);

  // R9
  pll_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_sel_clr_o |-> $past(!osc_en_o));

  // R6
  cm_rst_only_no_scm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_rst_o |-> $past(!scm_en_i));

  // R8
  flag_with_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scm_flag_o) |-> (!clk_sel_o && $past(clk_sel_o)));

  // R3
  rst_gen_on_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_gen_start_o |-> (!clk_sel_o && !cm_rst_o));

  // R4
  no_check_without_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !qc_start_o);

  // R4 (window length of at least two cycles)
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qc_start_o |=> !qc_start_o);

  // R7
  fast_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_o && !osc_en_o) |-> ($past(fast_wake_i) && !mon_en_o));
endmodule

bind stop_wake_ctrl stop_wake_ctrl_chk u_chk (.*);

// File: tb/tb_stop_wake_ctrl.sv
module tb_stop_wake_ctrl;
  localparam int W  = 3;
  localparam int MW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic stop_req_i = 0, ext_rst_i = 0, wake_irq_i = 0, fast_wake_i = 0;
  logic scm_en_i = 0, qc_pass_i = 0, scm_flag_clr_i = 0;
  logic osc_en_o, mon_en_o, qc_start_o, clk_sel_o, scm_flag_o;
  logic cm_rst_o, rst_gen_start_o, pll_sel_clr_o, cfg_default_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  stop_wake_ctrl #(.WIN_CYC(W), .MAX_WIN(MW)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 0;
    {stop_req_i, ext_rst_i, wake_irq_i, fast_wake_i} = '0;
    {scm_en_i, qc_pass_i, scm_flag_clr_i} = '0;
    tick();
    rst_ni = 1;
    tick();
  endtask

  task automatic enter_stop();
    stop_req_i = 1;
    tick();
    stop_req_i = 0;
    chk("R1 osc off in stop", osc_en_o, 0);
    chk("R1 mon off in stop", mon_en_o, 0);
  endtask

  // runs check windows; first pass at window p (p==MW: all fail)
  task automatic run_check(input int p);
    int tot;
    tot = (p < MW) ? (p + 1) * W : MW * W;
    for (int c = 0; c < tot; c++) begin
      qc_pass_i = ((c / W) == p);
      chk("R4 window start", qc_start_o, (c % W) == 0);
      chk("R8 osc on during check", osc_en_o, 1);
      tick();
    end
    qc_pass_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11
    chk("R11 clk_sel", clk_sel_o, 0);
    chk("R11 osc_en", osc_en_o, 1);
    chk("R11 mon_en", mon_en_o, 1);
    chk("R11 pulses", {cm_rst_o, rst_gen_start_o, pll_sel_clr_o, qc_start_o, scm_flag_o}, 0);

    // R1: non-wake inputs ignored in stop
    enter_stop();
    qc_pass_i = 1; fast_wake_i = 1; scm_en_i = 1; scm_flag_clr_i = 1;
    repeat (5) tick();
    chk("R1 stays in stop", osc_en_o, 0);
    chk("R1 no exit pulse", pll_sel_clr_o, 0);
    chk("R1 no check", qc_start_o, 0);

    // reset path sweep, with irq asserted too (R2 priority)
    for (int p = 0; p <= MW; p++) begin
      do_reset();
      enter_stop();
      ext_rst_i = 1; wake_irq_i = 1; fast_wake_i = 1; scm_en_i = 1;
      #1 chk("R2 async restore", cfg_default_o, 1);
      tick();
      ext_rst_i = 0; wake_irq_i = 0;
      chk("R9 pll clear", pll_sel_clr_o, 1);
      chk("R2 reset wins over irq", clk_sel_o, 0);
      run_check(p);
      chk("R3 rst gen pulse", rst_gen_start_o, 1);
      chk("R3 osc selected", clk_sel_o, 0);
      chk("R3 no cm reset", cm_rst_o, 0);
      tick();
      chk("R3 pulse width", rst_gen_start_o, 0);
    end

    // normal interrupt path: modes (fast,scm) = 00,10,01
    for (int m = 0; m < 3; m++) begin
      for (int p = 0; p <= MW; p++) begin
        do_reset();
        fast_wake_i = (m == 1);
        scm_en_i = (m == 2);
        enter_stop();
        wake_irq_i = 1;
        tick();
        wake_irq_i = 0;
        chk("R9 pll clear", pll_sel_clr_o, 1);
        chk("R5 osc selected at start", clk_sel_o, 0);
        run_check(p);
        if (p < MW) begin
          chk("R5 pass on osc", clk_sel_o, 0);
          chk("R5 flag not set", scm_flag_o, 0);
          chk("R5 no cm reset", cm_rst_o, 0);
        end else if (scm_en_i) begin
          chk("R6 self clock", clk_sel_o, 1);
          chk("R6 no cm reset", cm_rst_o, 0);
          tick();
          chk("R6 self clock held", clk_sel_o, 1);
        end else begin
          chk("R6 cm reset pulse", cm_rst_o, 1);
          chk("R6 back to osc", clk_sel_o, 0);
          tick();
          chk("R6 cm pulse width", cm_rst_o, 0);
        end
        chk("R9 single pulse", pll_sel_clr_o, 0);
      end
    end

    // fast path
    for (int p = 0; p <= MW; p++) begin
      do_reset();
      fast_wake_i = 1; scm_en_i = 1;
      enter_stop();
      wake_irq_i = 1;
      tick();
      wake_irq_i = 0;
      chk("R9 pll clear", pll_sel_clr_o, 1);
      chk("R7 self clock now", clk_sel_o, 1);
      chk("R7 osc off", osc_en_o, 0);
      chk("R7 mon off", mon_en_o, 0);
      repeat (3 + p) tick();
      chk("R7 held", {clk_sel_o, osc_en_o}, 2);
      chk("R9 single pulse", pll_sel_clr_o, 0);
      fast_wake_i = 0;
      tick();
      chk("R8 still self clock", clk_sel_o, 1);
      run_check(p);
      if (p < MW) begin
        chk("R8 switch to osc", clk_sel_o, 0);
        chk("R8 flag set", scm_flag_o, 1);
        repeat (2) tick();
        chk("R10 flag sticky", scm_flag_o, 1);
        scm_flag_clr_i = 1;
        tick();
        scm_flag_clr_i = 0;
        chk("R10 flag cleared", scm_flag_o, 0);
      end else begin
        chk("R8 fail stays self clock", clk_sel_o, 1);
        chk("R8 fail no flag", scm_flag_o, 0);
      end
    end

    // R10: set wins over a simultaneous clear
    do_reset();
    fast_wake_i = 1; scm_en_i = 1;
    enter_stop();
    wake_irq_i = 1;
    tick();
    wake_irq_i = 0;
    fast_wake_i = 0;
    tick();
    scm_flag_clr_i = 1;
    run_check(0);
    scm_flag_clr_i = 0;
    chk("R10 set wins", scm_flag_o, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule